// File: doc/BRIEF.md
# Bus-Takeover SRAM Image Loader

This controller sits beside a small 8-bit CPU and preloads a program image into the SRAM on that CPU's bus before the CPU runs. When program mode is requested, it holds the CPU in reset and has the CPU float its address, data and read/write lines. It then writes a stream of image bytes, taken over a valid/ready byte input, into one of three address windows in ascending order.

The low address byte, the data byte and the write strobe are driven in parallel, each with a shared output-enable. The upper address bits reach the bus through an external serial-in/parallel-out register. The loader shifts those bits out and then pulses a latch strobe, and it does this again for every access, even when the upper bits have not changed. When the last address of the window has been written, the loader releases its own drivers, waits one cycle, and then hands the bus back by raising bus-enable and releasing reset on the same edge. A push-button input is debounced inside the block. Each accepted press gives the running CPU a fixed-length reset pulse.

Top module: `sram_image_loader`

## Requirements
- R1: When `prog_mode` is high and the loader is armed, both `cpu_bus_en` and `cpu_rst_n` are 0 one clock later. They stay 0 for the whole load, and the loader drives the bus (`bus_oe` = 1) only while both are 0. In the first cycle after the takeover, `bus_oe` is still 0.
- R2: `cpu_bus_en` never changes in a cycle in which `cpu_rst_n` does not also change. This holds both when the loader takes the bus and when it releases it.
- R3: `win_sel` selects the window, with SPACE = 2^AW: 2'b00 and 2'b11 give the top TOP_SIZE bytes (SPACE-TOP_SIZE to SPACE-1); 2'b01 gives the whole space (0 to SPACE-1); 2'b10 gives everything below the top region (0 to SPACE-TOP_SIZE-1). Each window address is written exactly once, in ascending order, with the stream bytes in arrival order. Addresses outside the window are not written.
- R4: For every write, the AW-8 upper address bits go out on `sr_dat` MSB first. Each bit takes two clocks: one with the bit on `sr_dat` and `sr_clk` low, then one with `sr_clk` high and `sr_dat` unchanged. Exactly one single-cycle `sr_lat` pulse follows the last bit.
- R5: The write strobe `bus_rw_n` (0 = write) falls only after the latch pulse and one setup cycle, and stays low for WE_CYCLES clocks. Address and data stay driven and unchanged for one more clock after it rises.
- R6: `img_ready` is 1 only while the loader is waiting for the next byte during a load. A byte is taken only on a clock where `img_valid` and `img_ready` are both 1. Gaps in `img_valid` only delay the load.
- R7: After the last write, `bus_oe` is 0 for at least one clock before `cpu_bus_en` and `cpu_rst_n` rise. `load_done` is 1 from that release onward.
- R8: After a load completes, the block stays in run mode while `prog_mode` stays high. A new load starts only after `prog_mode` has been seen low and then high again.
- R9: A level change on `button` (1 = pressed) is accepted after two synchronizer stages and 2^DB_BITS consecutive samples at the new level. The CPU reset therefore starts 2^DB_BITS+2 clocks after the press. A shorter glitch has no effect.
- R10: An accepted press while the CPU runs drives `cpu_rst_n` low for exactly RST_CYCLES clocks, with `cpu_bus_en` held at 1. Releasing the button produces no pulse.
- R11: While `rst` is high, and right after it: `cpu_bus_en`=1, `cpu_rst_n`=1, `bus_oe`=0, `bus_rw_n`=1, `img_ready`=0, `load_done`=0, and `sr_dat`, `sr_clk`, `sr_lat` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_mode | input | 1 | 1 = program (load), 0 = run |
| win_sel | input | 2 | Load window select, sampled when a load starts |
| img_valid | input | 1 | Image byte valid |
| img_data | input | 8 | Image byte |
| img_ready | output | 1 | Loader accepts a byte this cycle |
| button | input | 1 | Raw push-button level, 1 = pressed |
| cpu_rst_n | output | 1 | CPU reset, active low |
| cpu_bus_en | output | 1 | CPU bus enable; 0 makes the CPU float its bus |
| bus_addr_lo | output | 8 | Address bits 7:0 |
| bus_data | output | 8 | Write data |
| bus_rw_n | output | 1 | Read/write line, 0 = write strobe |
| bus_oe | output | 1 | Enable for the loader's address, data and R/W drivers |
| sr_dat | output | 1 | Serial data to the upper-address register |
| sr_clk | output | 1 | Shift clock to the upper-address register |
| sr_lat | output | 1 | Latch strobe to the upper-address register |
| load_done | output | 1 | Last window address written and bus returned |

## Verification
A wrong sequencer state shows up within a clock: `cpu_bus_en` and `cpu_rst_n` move apart, or `bus_oe` rises while the CPU still owns the bus. A bad address counter or a skipped reshift is caught by rebuilding each write address from the external register model and comparing it with the next expected address at the strobe's rising edge, so a single wrong byte fails the same load. A wrong debounce or pulse counter shows at `cpu_rst_n`, either in the clock on which the pulse starts or in its length.

// File: rtl/imgload_pkg.sv
package imgload_pkg;

    typedef enum logic [2:0] {
        LD_RUN, LD_GRAB, LD_WAIT, LD_SHIFT, LD_SETUP, LD_STROBE, LD_HOLD, LD_FLOAT
    } ld_state_t;

    typedef enum logic [1:0] {
        SH_IDLE, SH_BIT, SH_LAT
    } sh_state_t;

    typedef enum logic [1:0] {
        WIN_TOP = 2'b00, WIN_FULL = 2'b01, WIN_LOW = 2'b10, WIN_TOP2 = 2'b11
    } win_t;

    typedef struct packed {
        logic oe;
        logic wr_n;
        logic ready;
    } bus_ctl_t;

    function automatic int unsigned win_first(win_t w, int unsigned space, int unsigned top);
        return (w == WIN_FULL || w == WIN_LOW) ? 0 : space - top;
    endfunction

    function automatic int unsigned win_last(win_t w, int unsigned space, int unsigned top);
        return (w == WIN_LOW) ? space - top - 1 : space - 1;
    endfunction

endpackage

// File: rtl/hi_addr_shifter.sv
module hi_addr_shifter
    import imgload_pkg::*;
#(
    parameter int HB = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [HB-1:0] value,
    output logic          sr_dat,
    output logic          sr_clk,
    output logic          sr_lat,
    output logic          fin
);
    localparam int NW = $clog2(HB) + 1;
    localparam logic [NW-1:0] LASTB = NW'(HB - 1);

    sh_state_t     st;
    logic [HB-1:0] sreg;
    logic [NW-1:0] nbit;
    logic          phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= SH_IDLE;
            sreg  <= '0;
            nbit  <= '0;
            phase <= 1'b0;
        end else begin
            unique case (st)
                SH_IDLE: if (start) begin
                    sreg  <= value;
                    nbit  <= '0;
                    phase <= 1'b0;
                    st    <= SH_BIT;
                end
                SH_BIT: begin
                    if (!phase) begin
                        phase <= 1'b1;
                    end else begin
                        phase <= 1'b0;
                        sreg  <= sreg << 1;
                        if (nbit == LASTB) st <= SH_LAT;
                        else               nbit <= nbit + 1'b1;
                    end
                end
                default: st <= SH_IDLE;
            endcase
        end
    end

    always_comb begin
        sr_dat = (st == SH_BIT) ? sreg[HB-1] : 1'b0;
        sr_clk = (st == SH_BIT) && phase;
        sr_lat = (st == SH_LAT);
        fin    = (st == SH_LAT);
    end
endmodule

// File: rtl/btn_reset_gen.sv
module btn_reset_gen #(
    parameter int DB_BITS = 16,
    parameter int PULSE   = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic button,
    input  logic run_ok,
    output logic hold
);
    localparam int PW = $clog2(PULSE + 1);

    logic               s1, s2, level;
    logic [DB_BITS-1:0] cnt;
    logic [PW-1:0]      pc;
    logic               press;

    assign press = s2 && !level && (&cnt);

    always_ff @(posedge clk) begin
        if (rst) begin
            s1    <= 1'b0;
            s2    <= 1'b0;
            level <= 1'b0;
            cnt   <= '0;
            pc    <= '0;
        end else begin
            s1 <= button;
            s2 <= s1;
            if (s2 == level) begin
                cnt <= '0;
            end else if (&cnt) begin
                level <= s2;
                cnt   <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
            if (press && run_ok) pc <= PW'(PULSE);
            else if (pc != '0)   pc <= pc - 1'b1;
        end
    end

    assign hold = (pc != '0);
endmodule

// File: rtl/sram_image_loader.sv
module sram_image_loader
    import imgload_pkg::*;
#(
    parameter int AW         = 16,
    parameter int TOP_SIZE   = 8192,
    parameter int WE_CYCLES  = 2,
    parameter int DB_BITS    = 16,
    parameter int RST_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       prog_mode,
    input  logic [1:0] win_sel,
    input  logic       img_valid,
    input  logic [7:0] img_data,
    output logic       img_ready,
    input  logic       button,
    output logic       cpu_rst_n,
    output logic       cpu_bus_en,
    output logic [7:0] bus_addr_lo,
    output logic [7:0] bus_data,
    output logic       bus_rw_n,
    output logic       bus_oe,
    output logic       sr_dat,
    output logic       sr_clk,
    output logic       sr_lat,
    output logic       load_done
);
    localparam int          HB    = AW - 8;
    localparam int unsigned SPACE = 2 ** AW;
    localparam int          WEW   = $clog2(WE_CYCLES + 1);

    ld_state_t      state;
    logic [AW-1:0]  addr, last, first_a, last_a;
    logic [7:0]     dbyte;
    logic [WEW-1:0] we_cnt;
    logic           armed, done, accept, shift_fin, btn_hold;
    bus_ctl_t       ctl;

    always_comb begin
        first_a = AW'(win_first(win_t'(win_sel), SPACE, TOP_SIZE));
        last_a  = AW'(win_last(win_t'(win_sel), SPACE, TOP_SIZE));
    end

    assign accept = (state == LD_WAIT) && img_valid;

    hi_addr_shifter #(.HB(HB)) u_shift (
        .clk    (clk),
        .rst    (rst),
        .start  (accept),
        .value  (addr[AW-1:8]),
        .sr_dat (sr_dat),
        .sr_clk (sr_clk),
        .sr_lat (sr_lat),
        .fin    (shift_fin)
    );

    btn_reset_gen #(.DB_BITS(DB_BITS), .PULSE(RST_CYCLES)) u_btn (
        .clk    (clk),
        .rst    (rst),
        .button (button),
        .run_ok (state == LD_RUN),
        .hold   (btn_hold)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= LD_RUN;
            addr   <= '0;
            last   <= '0;
            dbyte  <= '0;
            we_cnt <= '0;
            armed  <= 1'b1;
            done   <= 1'b0;
        end else begin
            unique case (state)
                LD_RUN: begin
                    if (!prog_mode) armed <= 1'b1;
                    if (prog_mode && armed && !btn_hold) begin
                        addr  <= first_a;
                        last  <= last_a;
                        done  <= 1'b0;
                        armed <= 1'b0;
                        state <= LD_GRAB;
                    end
                end
                LD_GRAB:  state <= LD_WAIT;
                LD_WAIT: if (img_valid) begin
                    dbyte <= img_data;
                    state <= LD_SHIFT;
                end
                LD_SHIFT: if (shift_fin) state <= LD_SETUP;
                LD_SETUP: begin
                    we_cnt <= '0;
                    state  <= LD_STROBE;
                end
                LD_STROBE: begin
                    we_cnt <= we_cnt + 1'b1;
                    if (we_cnt == WEW'(WE_CYCLES - 1)) state <= LD_HOLD;
                end
                LD_HOLD: begin
                    if (addr == last) begin
                        state <= LD_FLOAT;
                    end else begin
                        addr  <= addr + 1'b1;
                        state <= LD_WAIT;
                    end
                end
                default: begin
                    done  <= 1'b1;
                    state <= LD_RUN;
                end
            endcase
        end
    end

    always_comb begin
        ctl.oe    = (state inside {LD_WAIT, LD_SHIFT, LD_SETUP, LD_STROBE, LD_HOLD});
        ctl.wr_n  = (state != LD_STROBE);
        ctl.ready = (state == LD_WAIT);
    end

    assign cpu_bus_en  = (state == LD_RUN);
    assign cpu_rst_n   = (state == LD_RUN) && !btn_hold;
    assign bus_oe      = ctl.oe;
    assign bus_rw_n    = ctl.wr_n;
    assign img_ready   = ctl.ready;
    assign bus_addr_lo = ctl.oe ? addr[7:0] : 8'h00;
    assign bus_data    = ctl.oe ? dbyte : 8'h00;
    assign load_done   = done;
endmodule

// File: rtl/sram_image_loader_checks.sv
module sram_image_loader_checks #(
    parameter int WE_CYCLES = 2
) (
    input logic clk,
    input logic rst,
    input logic cpu_bus_en,
    input logic cpu_rst_n,
    input logic bus_oe,
    input logic bus_rw_n,
    input logic img_ready,
    input logic sr_dat,
    input logic sr_clk,
    input logic sr_lat
);
    logic       lat_seen;
    logic [7:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_seen <= 1'b0;
            low_cnt  <= '0;
        end else begin
            if (sr_lat)        lat_seen <= 1'b1;
            else if (!bus_rw_n) lat_seen <= 1'b0;
            low_cnt <= bus_rw_n ? 8'd0 : low_cnt + 8'd1;
        end
    end

    a_r1_cpu_held_while_driven: assert property (@(posedge clk) disable iff (rst)
        bus_oe |-> (!cpu_bus_en && !cpu_rst_n));

    a_r2_enable_reset_together: assert property (@(posedge clk) disable iff (rst)
        !$stable(cpu_bus_en) |-> !$stable(cpu_rst_n));

    a_r7_float_before_release: assert property (@(posedge clk) disable iff (rst)
        $rose(cpu_bus_en) |-> (!$past(bus_oe) && !bus_oe));

    a_r4_data_steady_at_clock: assert property (@(posedge clk) disable iff (rst)
        $rose(sr_clk) |-> $stable(sr_dat));

    a_r4_single_latch_pulse: assert property (@(posedge clk) disable iff (rst)
        sr_lat |=> !sr_lat);

    a_r5_strobe_after_latch: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_rw_n) |-> lat_seen);

    a_r5_strobe_width: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_rw_n) |-> (low_cnt == 8'(WE_CYCLES)));

    a_r6_ready_only_loading: assert property (@(posedge clk) disable iff (rst)
        img_ready |-> !cpu_bus_en);
endmodule

bind sram_image_loader sram_image_loader_checks #(.WE_CYCLES(WE_CYCLES)) u_checks (
    .clk        (clk),
    .rst        (rst),
    .cpu_bus_en (cpu_bus_en),
    .cpu_rst_n  (cpu_rst_n),
    .bus_oe     (bus_oe),
    .bus_rw_n   (bus_rw_n),
    .img_ready  (img_ready),
    .sr_dat     (sr_dat),
    .sr_clk     (sr_clk),
    .sr_lat     (sr_lat)
);

// File: tb/sram_image_loader_tb_top.sv
module sram_image_loader_tb_top;
    localparam int AW = 10, HB = 2, TOP = 64, DBB = 4, RSTC = 16;

    logic clk = 1'b0, rst = 1'b1, prog_mode = 1'b0, img_valid = 1'b0, button = 1'b0;
    logic [1:0] win_sel = 2'b00;
    logic [7:0] img_data = 8'h00;
    logic img_ready, cpu_rst_n, cpu_bus_en, bus_rw_n, bus_oe, sr_dat, sr_clk, sr_lat, load_done;
    logic [7:0] bus_addr_lo, bus_data;

    always #10 clk = ~clk;

    sram_image_loader #(.AW(AW), .TOP_SIZE(TOP), .WE_CYCLES(2), .DB_BITS(DBB),
                        .RST_CYCLES(RSTC)) dut_i (
        .clk(clk), .rst(rst), .prog_mode(prog_mode), .win_sel(win_sel),
        .img_valid(img_valid), .img_data(img_data), .img_ready(img_ready),
        .button(button), .cpu_rst_n(cpu_rst_n), .cpu_bus_en(cpu_bus_en),
        .bus_addr_lo(bus_addr_lo), .bus_data(bus_data), .bus_rw_n(bus_rw_n),
        .bus_oe(bus_oe), .sr_dat(sr_dat), .sr_clk(sr_clk), .sr_lat(sr_lat),
        .load_done(load_done));

    // Scenario table: win_sel, stall, seed, expected first, expected last
    localparam logic [30:0] SCEN [0:3] = '{
        {2'b00, 1'b0, 8'h3C, 10'd960, 10'd1023},
        {2'b10, 1'b1, 8'h5A, 10'd0,   10'd959},
        {2'b01, 1'b0, 8'hC3, 10'd0,   10'd1023},
        {2'b11, 1'b1, 8'h11, 10'd960, 10'd1023}
    };

    int checks = 0, fails = 0, cyc = 0;
    logic [7:0]    mem [0:1023];
    logic [HB-1:0] sh = '0, hi_q = '0;
    int wr_count = 0, order_err = 0, lat_err = 0, lat_since = 0, exp_addr = 0;
    int strobe_err = 0, r2_err = 0, r7_err = 0, low_run = 0;
    logic [7:0] cap_lo = 0, cap_d = 0;
    logic prev_be = 1'b1, prev_rn = 1'b1, prev_oe = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // External upper-address register model
    always @(posedge sr_clk) sh <= {sh[HB-2:0], sr_dat};
    always @(posedge sr_lat) begin
        hi_q <= sh;
        lat_since++;
    end

    // SRAM model: write on rising edge of the strobe
    always @(posedge bus_rw_n) begin
        if (bus_oe === 1'b1) begin
            if (int'({hi_q, bus_addr_lo}) != exp_addr) order_err++;
            if (lat_since != 1) lat_err++;
            lat_since = 0;
            mem[{hi_q, bus_addr_lo}] = bus_data;
            exp_addr++;
            wr_count++;
        end
    end

    // Protocol monitors sampled away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            if (cpu_bus_en !== prev_be && cpu_rst_n === prev_rn) r2_err++;
            if (cpu_bus_en && !prev_be && prev_oe) r7_err++;
            if (!bus_rw_n) begin
                if (low_run == 0) begin cap_lo = bus_addr_lo; cap_d = bus_data; end
                else if (bus_addr_lo != cap_lo || bus_data != cap_d) strobe_err++;
                low_run++;
            end else if (low_run != 0) begin
                if (low_run != 2 || !bus_oe || bus_addr_lo != cap_lo || bus_data != cap_d)
                    strobe_err++;
                low_run = 0;
            end
        end
        prev_be = cpu_bus_en; prev_rn = cpu_rst_n; prev_oe = bus_oe;
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=0", cyc);
            summary();
            $finish;
        end
    end

    task automatic send_byte(input logic [7:0] b, input bit stall);
        if (stall) begin
            @(negedge clk); img_valid = 1'b0;
            repeat (2) @(negedge clk);
        end
        @(negedge clk); img_valid = 1'b1; img_data = b;
        while (!img_ready) @(negedge clk);
        @(posedge clk);
    endtask

    // count cycles with cpu_rst_n low in a window; report first low index
    task automatic watch_reset(input int n, output int lows, output int first, output int be_low);
        lows = 0; first = -1; be_low = 0;
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            if (!cpu_rst_n) begin lows++; if (first < 0) first = i; end
            if (!cpu_bus_en) be_low++;
        end
    endtask

    initial begin
        int lows, first, be_low, w0, size, bad;
        logic [1:0] ws; logic st; logic [7:0] seed; int fa, la;

        repeat (3) @(negedge clk);
        // R11: reset values
        check(cpu_bus_en && cpu_rst_n && !bus_oe && bus_rw_n && !img_ready && !load_done
              && !sr_dat && !sr_clk && !sr_lat, "R11 reset state", 0, 1);
        rst = 1'b0;
        @(negedge clk);
        check(cpu_bus_en && cpu_rst_n && !bus_oe && !load_done, "R11 after reset", 0, 1);

        // R6: valid while running is not taken
        img_valid = 1'b1;
        repeat (5) @(negedge clk);
        check(!img_ready && wr_count == 0, "R6 no accept in run", wr_count, 0);
        img_valid = 1'b0;

        for (int s = 0; s < 4; s++) begin
            {ws, st, seed, fa, la} = {SCEN[s], 44'd0} >> 44;
            ws = SCEN[s][30:29]; st = SCEN[s][28]; seed = SCEN[s][27:20];
            fa = int'(SCEN[s][19:10]); la = int'(SCEN[s][9:0]);
            size = la - fa + 1;
            for (int a = 0; a < 1024; a++) mem[a] = 8'hEE;
            @(negedge clk); prog_mode = 1'b0; win_sel = ws;
            repeat (2) @(negedge clk);
            w0 = wr_count; exp_addr = fa; lat_since = 0;
            prog_mode = 1'b1;
            @(negedge clk);
            check(!cpu_bus_en && !cpu_rst_n && !bus_oe, "R1 takeover", cpu_bus_en, 0);
            if (st) begin
                repeat (20) @(negedge clk);
                check(img_ready && wr_count == w0, "R6 stall keeps waiting", wr_count - w0, 0);
            end
            for (int k = 0; k < size; k++) send_byte(8'(k) ^ seed, st);
            @(negedge clk); img_valid = 1'b0;
            for (int t = 0; t < 40 && !load_done; t++) @(negedge clk);
            check(load_done && cpu_bus_en && cpu_rst_n && !bus_oe, "R7 handback", load_done, 1);
            check(wr_count - w0 == size, "R3 write count", wr_count - w0, size);
            bad = 0;
            for (int a = 0; a < 1024; a++) begin
                if (a >= fa && a <= la) begin
                    if (mem[a] != (8'(a - fa) ^ seed)) bad++;
                end else if (mem[a] != 8'hEE) bad++;
            end
            check(bad == 0, "R3 memory image", bad, 0);
            check(order_err == 0, "R3 ascending order", order_err, 0);
            check(lat_err == 0, "R4 one reshift per write", lat_err, 0);
            check(strobe_err == 0, "R5 strobe shape", strobe_err, 0);
            // R8: holding prog_mode high does not restart
            w0 = wr_count;
            repeat (40) @(negedge clk);
            check(cpu_bus_en && load_done && wr_count == w0, "R8 no reload", wr_count - w0, 0);
        end
        check(r2_err == 0, "R2 enable/reset same edge", r2_err, 0);
        check(r7_err == 0, "R7 float before release", r7_err, 0);

        // R9: short glitch ignored
        prog_mode = 1'b0;
        @(negedge clk); button = 1'b1;
        repeat (10) @(negedge clk); button = 1'b0;
        watch_reset(60, lows, first, be_low);
        check(lows == 0, "R9 glitch ignored", lows, 0);

        // R9/R10: long press
        button = 1'b1;
        watch_reset(30, lows, first, be_low);
        button = 1'b0;
        begin
            int l2, f2, b2;
            watch_reset(60, l2, f2, b2);
            check(first == (1 << DBB) + 2, "R9 debounce latency", first, (1 << DBB) + 2);
            check(lows + l2 == RSTC, "R10 pulse length", lows + l2, RSTC);
            check(be_low + b2 == 0, "R10 bus enable stays high", be_low + b2, 0);
        end
        check(r2_err == 0, "R2 enable/reset after button", r2_err, 0);

        summary();
        $finish;
    end
endmodule